// File: doc/BRIEF.md
# External Bus Wait-State Stretch Controller

This block lengthens external bus accesses by inserting stretch cycles (wait states), deciding the length separately for each chip select line. A small control register holds two shared, independently programmable stretch counts. A 2-bit selector for each chip select, supplied by the surrounding memory controller on `cs_cfg`, picks one of four behaviours for that line:
- keep it disabled,
- stretch by the first count,
- stretch by the second count,
- stretch under control of an active-low external wait pin, with a guaranteed floor of two stretch cycles.

An access begins with a one-cycle strobe carrying the decoded chip select index. The sequencer then walks the states `ST_IDLE`, `ST_BASE`, `ST_COUNT` or `ST_WAITPIN`, `ST_DONE`:
- `ST_IDLE -> ST_BASE` when a strobe is taken.
- `ST_BASE -> ST_DONE` when no stretch applies.
- `ST_BASE -> ST_COUNT` for a non-zero count.
- `ST_BASE -> ST_WAITPIN` for wait-pin control.
- `ST_COUNT -> ST_DONE` when the count is used up.
- `ST_WAITPIN -> ST_DONE` once the floor is met and the wait pin is sampled high.
- `ST_DONE -> ST_IDLE` always.

`bus_ready` is high only in `ST_DONE`. The chip select enable is driven from `ST_BASE` through `ST_DONE`.

Stretching applies only in the two expanded bus modes. The operating mode is `op_mode`: bit 1 set means an emulation mode, bit 0 set means an expanded mode. In emulation modes, register writes are also passed out to the external bus, and reads return external bus data.

Top module: `xbus_stretch_ctrl`

## Requirements
- R1: After reset the register reads 0x77 in a non-emulation mode. The first count occupies bits 2:0 and the second count bits 6:4. Bits 3 and 7 always read 0.
- R2: The register can be written in any cycle through `reg_wr`/`reg_wdata`. In a non-emulation mode it reads back the written count fields on the next cycle.
- R3: In an emulation mode (`op_mode[1]`=1), a write also drives `ext_wr` high with `ext_wdata` equal to the written byte in the same cycle, and still updates the register. In that mode `reg_rdata` returns `ext_rdata`. Outside emulation, `ext_wr` stays low.
- R4: Selector 01 in an expanded mode stretches by the first count N. `bus_ready` stays low for 1+N cycles after the strobe is taken, so N=0 adds no cycle.
- R5: Selector 10 in an expanded mode stretches by the second count in the same way.
- R6: Selector 00 never asserts that chip select. The access completes with no stretch, with `bus_ready` low for 1 cycle.
- R7: Selector 11 in an expanded mode stretches under control of `wait_n` (active low, sampled on the clock edge), with at least 2 stretch cycles. The access ends after the first stretch cycle, at or after the second, in which `wait_n` is sampled high.
- R8: In modes 00 (normal single-chip) and 10 (emulation single-chip), no selector stretches. `bus_ready` is low for 1 cycle after the strobe.
- R9: `bus_ready` is a one-cycle pulse. The enable of the selected chip select is one-hot and is held from the cycle after the strobe through the ready cycle.
- R10: A strobe arriving while an access is in progress, including its ready cycle, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, or external data in emulation |
| ext_rdata | input | 8 | External bus read data used in emulation |
| ext_wr | output | 1 | Forwarded write strobe in emulation |
| ext_wdata | output | 8 | Forwarded write data |
| cs_cfg | input | 8 | Per-chip-select 2-bit selectors, chip select i in bits 2i+1:2i |
| op_mode | input | 2 | Bit 1 emulation, bit 0 expanded |
| acc_start | input | 1 | Access-start strobe |
| acc_cs_idx | input | 2 | Decoded chip select index |
| wait_n | input | 1 | External wait input, active low |
| cs_en | output | 4 | Chip select enables |
| bus_ready | output | 1 | Access-complete pulse; low means hold |

## Verification
Accesses are issued through every selector code and every operating mode, with count values of zero, small and maximum, so that a swapped count field, a missing zero case or a stretch leaking into single-chip modes each shows up as a wrong ready latency. The wait-pin selector is tried with the pin released at once, after one cycle and after four cycles. This separates the two-cycle floor from a pin-driven end. Directed tests cover the reset value, reserved bits, emulation forwarding and read substitution, and a strobe repeated during a busy access.

// File: rtl/xbs_pkg.sv
package xbs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BASE,
        ST_COUNT,
        ST_WAITPIN,
        ST_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        SRC_OFF     = 2'b00,
        SRC_CNT_A   = 2'b01,
        SRC_CNT_B   = 2'b10,
        SRC_WAITPIN = 2'b11
    } src_sel_t;

    typedef enum logic [1:0] {
        KIND_NONE,
        KIND_COUNT,
        KIND_WAIT
    } stretch_kind_t;

    function automatic logic mode_is_expanded(input logic [1:0] mode);
        return mode[0];
    endfunction

    function automatic logic mode_is_emulation(input logic [1:0] mode);
        return mode[1];
    endfunction

endpackage

// File: rtl/xbs_ctrl_reg.sv
module xbs_ctrl_reg #(
    parameter int CNT_W = 3,
    localparam int REG_W = 2 * (CNT_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             emul,
    input  logic [REG_W-1:0] ext_rdata,
    output logic [REG_W-1:0] rdata,
    output logic             ext_wr,
    output logic [REG_W-1:0] ext_wdata,
    output logic [CNT_W-1:0] cnt_a,
    output logic [CNT_W-1:0] cnt_b
);
    localparam int HI_LSB = CNT_W + 1;

    logic [CNT_W-1:0] cnt_a_q, cnt_b_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_a_q <= '1;
            cnt_b_q <= '1;
        end else if (wr) begin
            cnt_a_q <= wdata[CNT_W-1:0];
            cnt_b_q <= wdata[HI_LSB +: CNT_W];
        end
    end

    always_comb begin
        rdata     = emul ? ext_rdata : {1'b0, cnt_b_q, 1'b0, cnt_a_q};
        ext_wr    = wr && emul;
        ext_wdata = wdata;
        cnt_a     = cnt_a_q;
        cnt_b     = cnt_b_q;
    end

endmodule

// File: rtl/xbs_src_mux.sv
module xbs_src_mux
    import xbs_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int CNT_W  = 3,
    localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic [2*NUM_CS-1:0] cs_cfg,
    input  logic [IDX_W-1:0]    idx,
    input  logic [CNT_W-1:0]    cnt_a,
    input  logic [CNT_W-1:0]    cnt_b,
    input  logic                expanded,
    output logic                sel_enabled,
    output stretch_kind_t       sel_kind,
    output logic [CNT_W-1:0]    sel_count
);
    logic          line_en    [NUM_CS];
    stretch_kind_t line_kind  [NUM_CS];
    logic [CNT_W-1:0] line_cnt [NUM_CS];

    for (genvar i = 0; i < NUM_CS; i++) begin : g_line
        src_sel_t code;
        assign code = src_sel_t'(cs_cfg[2*i +: 2]);
        always_comb begin
            line_en[i]   = (code != SRC_OFF);
            line_kind[i] = KIND_NONE;
            line_cnt[i]  = '0;
            if (expanded) begin
                unique case (code)
                    SRC_OFF:     line_kind[i] = KIND_NONE;
                    SRC_CNT_A: begin
                        line_kind[i] = KIND_COUNT;
                        line_cnt[i]  = cnt_a;
                    end
                    SRC_CNT_B: begin
                        line_kind[i] = KIND_COUNT;
                        line_cnt[i]  = cnt_b;
                    end
                    SRC_WAITPIN: line_kind[i] = KIND_WAIT;
                endcase
            end
        end
    end

    always_comb begin
        sel_enabled = 1'b0;
        sel_kind    = KIND_NONE;
        sel_count   = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (idx == IDX_W'(i)) begin
                sel_enabled = line_en[i];
                sel_kind    = line_kind[i];
                sel_count   = line_cnt[i];
            end
        end
    end

endmodule

// File: rtl/xbs_seq.sv
module xbs_seq
    import xbs_pkg::*;
#(
    parameter int NUM_CS     = 4,
    parameter int CNT_W      = 3,
    parameter int WAIT_FLOOR = 2,
    localparam int IDX_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int FLOOR_W = $clog2(WAIT_FLOOR + 1),
    localparam int CW      = (CNT_W > FLOOR_W) ? CNT_W : FLOOR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_start,
    input  logic [IDX_W-1:0]  idx,
    input  logic              enabled,
    input  stretch_kind_t     kind,
    input  logic [CNT_W-1:0]  count,
    input  logic              wait_n,
    output logic [NUM_CS-1:0] cs_en,
    output logic              bus_ready,
    output logic              busy
);
    seq_state_t       state_q, state_d;
    logic [IDX_W-1:0] act_idx_q;
    logic             act_en_q;
    stretch_kind_t    act_kind_q;
    logic [CW-1:0]    cnt_q, cnt_d;
    logic             take;

    assign take = (state_q == ST_IDLE) && acc_start;

    // state register and access latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            act_idx_q  <= '0;
            act_en_q   <= 1'b0;
            act_kind_q <= KIND_NONE;
            cnt_q      <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (take) begin
                act_idx_q  <= idx;
                act_en_q   <= enabled;
                act_kind_q <= kind;
            end
        end
    end

    // next state and stretch counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (acc_start) begin
                    state_d = ST_BASE;
                    cnt_d   = (kind == KIND_WAIT) ? CW'(WAIT_FLOOR) : CW'(count);
                end
            end
            ST_BASE: begin
                unique case (act_kind_q)
                    KIND_COUNT: state_d = (cnt_q == '0) ? ST_DONE : ST_COUNT;
                    KIND_WAIT:  state_d = ST_WAITPIN;
                    default:    state_d = ST_DONE;
                endcase
            end
            ST_COUNT: begin
                cnt_d = cnt_q - 1'b1;
                if (cnt_q <= CW'(1)) state_d = ST_DONE;
            end
            ST_WAITPIN: begin
                if (cnt_q > CW'(1)) cnt_d = cnt_q - 1'b1;
                else if (wait_n)    state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        bus_ready = (state_q == ST_DONE);
        for (int i = 0; i < NUM_CS; i++) begin
            cs_en[i] = busy && act_en_q && (act_idx_q == IDX_W'(i));
        end
    end

endmodule

// File: rtl/xbus_stretch_ctrl.sv
module xbus_stretch_ctrl
    import xbs_pkg::*;
#(
    parameter int NUM_CS     = 4,
    parameter int CNT_W      = 3,
    parameter int WAIT_FLOOR = 2,
    localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int REG_W = 2 * (CNT_W + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic [REG_W-1:0]    ext_rdata,
    output logic                ext_wr,
    output logic [REG_W-1:0]    ext_wdata,
    input  logic [2*NUM_CS-1:0] cs_cfg,
    input  logic [1:0]          op_mode,
    input  logic                acc_start,
    input  logic [IDX_W-1:0]    acc_cs_idx,
    input  logic                wait_n,
    output logic [NUM_CS-1:0]   cs_en,
    output logic                bus_ready
);
    logic [CNT_W-1:0] cnt_a, cnt_b, sel_count;
    logic             sel_enabled, seq_busy;
    stretch_kind_t    sel_kind;

    xbs_ctrl_reg #(.CNT_W(CNT_W)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .wdata     (reg_wdata),
        .emul      (mode_is_emulation(op_mode)),
        .ext_rdata (ext_rdata),
        .rdata     (reg_rdata),
        .ext_wr    (ext_wr),
        .ext_wdata (ext_wdata),
        .cnt_a     (cnt_a),
        .cnt_b     (cnt_b)
    );

    xbs_src_mux #(.NUM_CS(NUM_CS), .CNT_W(CNT_W)) u_mux (
        .cs_cfg      (cs_cfg),
        .idx         (acc_cs_idx),
        .cnt_a       (cnt_a),
        .cnt_b       (cnt_b),
        .expanded    (mode_is_expanded(op_mode)),
        .sel_enabled (sel_enabled),
        .sel_kind    (sel_kind),
        .sel_count   (sel_count)
    );

    xbs_seq #(.NUM_CS(NUM_CS), .CNT_W(CNT_W), .WAIT_FLOOR(WAIT_FLOOR)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_start (acc_start),
        .idx       (acc_cs_idx),
        .enabled   (sel_enabled),
        .kind      (sel_kind),
        .count     (sel_count),
        .wait_n    (wait_n),
        .cs_en     (cs_en),
        .bus_ready (bus_ready),
        .busy      (seq_busy)
    );

endmodule

// File: rtl/xbs_checker.sv
module xbs_checker #(
    parameter int NUM_CS = 4,
    parameter int CNT_W  = 3,
    localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int REG_W = 2 * (CNT_W + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2*NUM_CS-1:0] cs_cfg,
    input logic [1:0]          op_mode,
    input logic                acc_start,
    input logic [IDX_W-1:0]    acc_cs_idx,
    input logic [REG_W-1:0]    reg_rdata,
    input logic [NUM_CS-1:0]   cs_en,
    input logic                bus_ready,
    input logic                busy
);
    logic [1:0] idx_code;

    always_comb begin
        idx_code = 2'b00;
        for (int i = 0; i < NUM_CS; i++) begin
            if (acc_cs_idx == IDX_W'(i)) idx_code = cs_cfg[2*i +: 2];
        end
    end

    assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !op_mode[1] |-> (reg_rdata[CNT_W] == 1'b0 && reg_rdata[REG_W-1] == 1'b0));

    assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_start && !busy && idx_code == 2'b00) |=> (cs_en == '0));

    assert_wait_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_start && !busy && op_mode[0] && idx_code == 2'b11)
        |=> !bus_ready ##1 !bus_ready ##1 !bus_ready);

    assert_flat_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_start && !busy && !op_mode[0]) |=> ##1 bus_ready);

    assert_ready_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready);

    assert_cs_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_en));

    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bus_ready && cs_en != '0) |=> (cs_en == '0 || $stable(cs_en)));

endmodule

bind xbus_stretch_ctrl xbs_checker #(.NUM_CS(NUM_CS), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_cfg     (cs_cfg),
    .op_mode    (op_mode),
    .acc_start  (acc_start),
    .acc_cs_idx (acc_cs_idx),
    .reg_rdata  (reg_rdata),
    .cs_en      (cs_en),
    .bus_ready  (bus_ready),
    .busy       (seq_busy)
);

// File: tb/xbus_stretch_ctrl_test.sv
module xbus_stretch_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] ext_rdata = 8'hA5;
    logic       ext_wr;
    logic [7:0] ext_wdata;
    logic [7:0] cs_cfg = 8'hC9;   // CS0=01, CS1=10, CS2=00, CS3=11
    logic [1:0] op_mode = 2'b00;
    logic       acc_start = 1'b0;
    logic [1:0] acc_cs_idx = '0;
    logic       wait_n = 1'b1;
    logic [3:0] cs_en;
    logic       bus_ready;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 0;

    always #4 clk = ~clk;   // 125 MHz

    xbus_stretch_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ext_rdata(ext_rdata), .ext_wr(ext_wr),
        .ext_wdata(ext_wdata), .cs_cfg(cs_cfg), .op_mode(op_mode),
        .acc_start(acc_start), .acc_cs_idx(acc_cs_idx), .wait_n(wait_n),
        .cs_en(cs_en), .bus_ready(bus_ready)
    );

    typedef struct packed {
        logic [7:0] regv;
        logic [1:0] idx;
        logic [1:0] mode;
        logic [3:0] wl;
        logic [4:0] exp_low;
        logic [3:0] exp_cs;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{8'h77, 2'd0, 2'b01, 4'd0, 5'd8, 4'b0001, 4'd4},  // R4 max count
        '{8'h30, 2'd0, 2'b01, 4'd0, 5'd1, 4'b0001, 4'd4},  // R4 zero count
        '{8'h30, 2'd1, 2'b11, 4'd0, 5'd4, 4'b0010, 4'd5},  // R5 emulation expanded
        '{8'h52, 2'd0, 2'b11, 4'd0, 5'd3, 4'b0001, 4'd4},  // R4 count 2
        '{8'h52, 2'd1, 2'b01, 4'd0, 5'd6, 4'b0010, 4'd5},  // R5 count 5
        '{8'h77, 2'd2, 2'b01, 4'd0, 5'd1, 4'b0000, 4'd6},  // R6 disabled
        '{8'h77, 2'd3, 2'b01, 4'd0, 5'd3, 4'b1000, 4'd7},  // R7 pin free at once
        '{8'h77, 2'd3, 2'b11, 4'd1, 5'd3, 4'b1000, 4'd7},  // R7 pin held 1
        '{8'h77, 2'd3, 2'b01, 4'd4, 5'd6, 4'b1000, 4'd7},  // R7 pin held 4
        '{8'h77, 2'd0, 2'b00, 4'd0, 5'd1, 4'b0001, 4'd8},  // R8 single-chip
        '{8'h77, 2'd3, 2'b10, 4'd4, 5'd1, 4'b1000, 4'd8},  // R8 emul single-chip
        '{8'h77, 2'd1, 2'b10, 4'd0, 5'd1, 4'b0010, 4'd8}   // R8
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] d);
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic do_access(input logic [1:0] idx, input logic [1:0] mode, input int wl,
                             output int low, output logic [3:0] csacc);
        op_mode    = mode;
        acc_cs_idx = idx;
        acc_start  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        acc_start = 1'b0;
        low   = 0;
        csacc = '0;
        while (!bus_ready && low < 40) begin
            low++;
            csacc  = csacc | cs_en;
            wait_n = !(low >= 2 && (low - 1) <= wl);
            @(posedge clk);
            @(negedge clk);
        end
        csacc  = csacc | cs_en;
        wait_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        int low;
        logic [3:0] csacc;

        repeat (3) @(negedge clk);
        check("R1 reset value", {24'd0, reg_rdata}, 32'h77);
        check("R9 ready low at reset", {31'd0, bus_ready}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        write_reg(8'hFF);
        check("R1 reserved bits", {24'd0, reg_rdata}, 32'h77);
        write_reg(8'h25);
        check("R2 readback", {24'd0, reg_rdata}, 32'h25);
        check("R3 no forward outside emulation", {31'd0, ext_wr}, 32'd0);

        op_mode = 2'b11;
        #1;
        check("R3 read substitution", {24'd0, reg_rdata}, 32'hA5);
        @(negedge clk);
        reg_wdata = 8'h61;
        reg_wr    = 1'b1;
        #1;
        check("R3 write forwarded", {31'd0, ext_wr}, 32'd1);
        check("R3 forwarded data", {24'd0, ext_wdata}, 32'h61);
        @(posedge clk);
        @(negedge clk);
        reg_wr  = 1'b0;
        op_mode = 2'b01;
        #1;
        check("R3 emulation write stored", {24'd0, reg_rdata}, 32'h61);
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            op_mode = 2'b01;
            write_reg(VECS[v].regv);
            do_access(VECS[v].idx, VECS[v].mode, int'(VECS[v].wl), low, csacc);
            check($sformatf("R%0d vector %0d latency", VECS[v].req, v), 32'(low), 32'(VECS[v].exp_low));
            check($sformatf("R%0d vector %0d chip select", VECS[v].req, v), {28'd0, csacc}, {28'd0, VECS[v].exp_cs});
        end

        // R10: repeated strobe during a busy access, R9 single pulse
        op_mode = 2'b01;
        write_reg(8'h33);
        acc_cs_idx = 2'd0;
        acc_start  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        acc_cs_idx = 2'd1;
        low   = 0;
        csacc = '0;
        while (!bus_ready && low < 40) begin
            low++;
            csacc = csacc | cs_en;
            @(posedge clk);
            @(negedge clk);
        end
        csacc = csacc | cs_en;
        acc_start = 1'b0;
        check("R10 busy strobe latency", 32'(low), 32'd4);
        check("R10 busy strobe chip select", {28'd0, csacc}, 32'b0001);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R9 R10 ready not repeated", {31'd0, bus_ready}, 32'd0);
            check("R10 no second access", {28'd0, cs_en}, 32'd0);
        end

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule